// File: doc/BRIEF.md
# Control-Transfer Address Recorder

This block keeps a small history of where a processor's control flow last jumped. A source of control-transfer events presents a one-cycle strobe with the event kind and two 32-bit addresses: where the transfer left from and where it landed. The block keeps two address pairs. The branch pair always holds the most recent recorded transfer. The exception pair holds the branch pair as it stood just before the most recent interrupt or exception.

When an interrupt or exception arrives, the branch pair is first copied into the exception pair. The new addresses then go into the branch pair. Both moves happen on one clock edge. This keeps the last transfer that came before the fault.

A debug exception stops recording: it clears the recording flag and leaves the four registers alone. A debugger can then read out the history through a four-way read select. To resume recording, software writes the recording flag again through the control write port. The control register also holds a trace-message flag. While that flag is set, the address registers hold their values.

Top module: `xfr_recorder`

## Requirements
- R1: While reset is asserted, all four address registers read zero and the control read-back `cfgRdata` reads zero.
- R2: A branch event (`evtKind` = 0) with recording active loads `evtFrom` into branch-from and `evtTo` into branch-to. The exception pair is left unchanged.
- R3: An interrupt (`evtKind` = 1) or exception (`evtKind` = 2) with recording active copies the old branch-from and branch-to into exception-from and exception-to. On the same edge it loads the new `evtFrom`/`evtTo` into the branch pair, and the copy uses the values from before that edge.
- R4: A debug exception (`evtKind` = 3) clears the recording flag (control bit 0) and changes none of the four address registers. It clears the flag even when a control write in the same cycle sets it.
- R5: While the recording flag is clear, no event of any kind changes any address register.
- R6: While the trace-message flag (control bit 6) is set, no event changes any address register.
- R7: A control write stores `cfgWdata` bit 0 as the recording flag and bit 6 as the trace-message flag. `cfgRdata` returns those two bits in the same positions, and every other bit of `cfgRdata` reads zero. An event in the same cycle as a control write is judged by the flags from before the write.
- R8: `rdData` shows the register chosen by `rdSel`, combinationally: 0 = branch-from, 1 = branch-to, 2 = exception-from, 3 = exception-to.
- R9: Events on consecutive cycles are each recorded in turn. There is no dead cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| evtValid | input | 1 | Control-transfer event strobe, one cycle per event |
| evtKind | input | 2 | Event kind: 0 branch, 1 interrupt, 2 exception, 3 debug exception |
| evtFrom | input | ADDR_W | Source address of the transfer |
| evtTo | input | ADDR_W | Target address of the transfer |
| cfgWe | input | 1 | Control register write enable |
| cfgWdata | input | CFG_W | Control write data; bit 0 recording flag, bit 6 trace flag |
| cfgRdata | output | CFG_W | Control register read-back |
| rdSel | input | 2 | Address register select |
| rdData | output | ADDR_W | Selected address register |

## Verification
Every event and every control write takes effect on the rising edge where it is presented. The new register contents and flag values therefore appear at `rdData` and `cfgRdata` one edge after the stimulus. `rdData` follows `rdSel` with no further delay.

The bench drives each stimulus for exactly one cycle, starting at a falling edge. After the next rising edge it steps `rdSel` through all four values within the same low-going half period and compares each reading with its own model. It also checks the control read-back there. Same-cycle cases, such as a write colliding with a debug exception and an event beside a write, are checked at that same single-edge point.

// File: rtl/xfr_pkg.sv
package xfr_pkg;
  localparam int REC_BIT   = 0;
  localparam int TRACE_BIT = 6;
  localparam int NUM_REGS  = 4;

  typedef enum logic [1:0] {
    KIND_BRANCH = 2'd0,
    KIND_IRQ    = 2'd1,
    KIND_FAULT  = 2'd2,
    KIND_DEBUG  = 2'd3
  } xferKind_e;

  // register slots, in read-select order
  localparam int SLOT_BR_FROM = 0;
  localparam int SLOT_BR_TO   = 1;
  localparam int SLOT_EX_FROM = 2;
  localparam int SLOT_EX_TO   = 3;

  typedef struct packed {
    logic loadBranch;
    logic copyToExc;
  } xferStrobe_t;
endpackage

// File: rtl/xfr_ctrl.sv
module xfr_ctrl
  import xfr_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        evtValid,
  input  logic [1:0]  evtKind,
  input  logic        cfgWe,
  input  logic        wrRec,
  input  logic        wrTrace,
  output xferStrobe_t strb,
  output logic        recFlag,
  output logic        trFlag
);
  logic recFlagQ, trFlagQ;
  logic recOn, isDebug, isFault;

  always_comb begin
    recOn   = recFlagQ & ~trFlagQ;
    isDebug = evtValid && (xferKind_e'(evtKind) == KIND_DEBUG);
    isFault = (xferKind_e'(evtKind) == KIND_IRQ) || (xferKind_e'(evtKind) == KIND_FAULT);
    strb.loadBranch = evtValid & recOn & ~isDebug;
    strb.copyToExc  = evtValid & recOn & isFault;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      recFlagQ <= 1'b0;
      trFlagQ  <= 1'b0;
    end else begin
      if (cfgWe) begin
        recFlagQ <= wrRec;
        trFlagQ  <= wrTrace;
      end
      // a debug exception stops recording, even against a concurrent write
      if (isDebug) recFlagQ <= 1'b0;
    end
  end

  assign recFlag = recFlagQ;
  assign trFlag  = trFlagQ;
endmodule

// File: rtl/xfr_datapath.sv
module xfr_datapath
  import xfr_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  xferStrobe_t                      strb,
  input  logic [ADDR_W-1:0]                evtFrom,
  input  logic [ADDR_W-1:0]                evtTo,
  output logic [NUM_REGS-1:0][ADDR_W-1:0]  regsQ
);
  always_ff @(posedge clk) begin
    if (!rstN) begin
      regsQ <= '0;
    end else begin
      // copy reads the pre-edge branch pair; load overwrites it on the same edge
      if (strb.copyToExc) begin
        regsQ[SLOT_EX_FROM] <= regsQ[SLOT_BR_FROM];
        regsQ[SLOT_EX_TO]   <= regsQ[SLOT_BR_TO];
      end
      if (strb.loadBranch) begin
        regsQ[SLOT_BR_FROM] <= evtFrom;
        regsQ[SLOT_BR_TO]   <= evtTo;
      end
    end
  end
endmodule

// File: rtl/xfr_recorder.sv
module xfr_recorder
  import xfr_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CFG_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              evtValid,
  input  logic [1:0]        evtKind,
  input  logic [ADDR_W-1:0] evtFrom,
  input  logic [ADDR_W-1:0] evtTo,
  input  logic              cfgWe,
  input  logic [CFG_W-1:0]  cfgWdata,
  output logic [CFG_W-1:0]  cfgRdata,
  input  logic [1:0]        rdSel,
  output logic [ADDR_W-1:0] rdData
);
  xferStrobe_t                      strb;
  logic                             recFlag, trFlag;
  logic [NUM_REGS-1:0][ADDR_W-1:0]  regsQ;

  xfr_ctrl i_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .evtValid(evtValid),
    .evtKind (evtKind),
    .cfgWe   (cfgWe),
    .wrRec   (cfgWdata[REC_BIT]),
    .wrTrace (cfgWdata[TRACE_BIT]),
    .strb    (strb),
    .recFlag (recFlag),
    .trFlag  (trFlag)
  );

  xfr_datapath #(.ADDR_W(ADDR_W)) i_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strb   (strb),
    .evtFrom(evtFrom),
    .evtTo  (evtTo),
    .regsQ  (regsQ)
  );

  always_comb begin
    cfgRdata            = '0;
    cfgRdata[REC_BIT]   = recFlag;
    cfgRdata[TRACE_BIT] = trFlag;
    rdData              = regsQ[rdSel];
  end
endmodule

// File: rtl/xfr_recorder_chk.sv
module xfr_recorder_chk
  import xfr_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CFG_W  = 8
) (
  input logic                            clk,
  input logic                            rstN,
  input logic                            evtValid,
  input logic [1:0]                      evtKind,
  input logic [ADDR_W-1:0]               evtFrom,
  input logic [ADDR_W-1:0]               evtTo,
  input logic                            cfgWe,
  input logic [CFG_W-1:0]                cfgWdata,
  input logic [CFG_W-1:0]                cfgRdata,
  input logic                            recFlag,
  input logic                            trFlag,
  input logic [NUM_REGS-1:0][ADDR_W-1:0] regsQ
);
  localparam logic [CFG_W-1:0] CFG_MASK = (CFG_W'(1) << REC_BIT) | (CFG_W'(1) << TRACE_BIT);

  logic recOn, isDbg, isBr, isFlt;
  assign recOn = recFlag & ~trFlag;
  assign isDbg = evtValid && evtKind == 2'd3;
  assign isBr  = evtValid && evtKind == 2'd0;
  assign isFlt = evtValid && (evtKind == 2'd1 || evtKind == 2'd2);

  p_reset_clear_r1: assert property (@(posedge clk)
    !rstN |=> (regsQ == '0 && cfgRdata == '0));

  p_branch_load_r2: assert property (@(posedge clk) disable iff (!rstN)
    isBr && recOn |=> regsQ[SLOT_BR_FROM] == $past(evtFrom) && regsQ[SLOT_BR_TO] == $past(evtTo)
      && $stable(regsQ[SLOT_EX_FROM]) && $stable(regsQ[SLOT_EX_TO]));

  p_copy_then_record_r3: assert property (@(posedge clk) disable iff (!rstN)
    isFlt && recOn |=> regsQ[SLOT_EX_FROM] == $past(regsQ[SLOT_BR_FROM])
      && regsQ[SLOT_EX_TO] == $past(regsQ[SLOT_BR_TO])
      && regsQ[SLOT_BR_FROM] == $past(evtFrom) && regsQ[SLOT_BR_TO] == $past(evtTo));

  p_debug_freeze_r4: assert property (@(posedge clk) disable iff (!rstN)
    isDbg |=> !recFlag && $stable(regsQ));

  p_hold_when_off_r5: assert property (@(posedge clk) disable iff (!rstN)
    !recFlag |=> $stable(regsQ));

  p_hold_in_trace_r6: assert property (@(posedge clk) disable iff (!rstN)
    trFlag |=> $stable(regsQ));

  p_cfg_write_r7: assert property (@(posedge clk) disable iff (!rstN)
    cfgWe && !isDbg |=> cfgRdata == ($past(cfgWdata) & CFG_MASK));
endmodule

bind xfr_recorder xfr_recorder_chk #(.ADDR_W(ADDR_W), .CFG_W(CFG_W)) i_chk (
  .clk(clk), .rstN(rstN), .evtValid(evtValid), .evtKind(evtKind),
  .evtFrom(evtFrom), .evtTo(evtTo), .cfgWe(cfgWe), .cfgWdata(cfgWdata),
  .cfgRdata(cfgRdata), .recFlag(recFlag), .trFlag(trFlag), .regsQ(regsQ)
);

// File: tb/test_xfr_recorder.sv
`timescale 1ns/1ps
module test_xfr_recorder;
  localparam real CLK_PERIOD = 10.0;
  localparam int  AW = 32;
  localparam int  CW = 8;

  logic          clk = 1'b0;
  logic          rstN;
  logic          evtValid;
  logic [1:0]    evtKind;
  logic [AW-1:0] evtFrom, evtTo;
  logic          cfgWe;
  logic [CW-1:0] cfgWdata, cfgRdata;
  logic [1:0]    rdSel;
  logic [AW-1:0] rdData;

  int checks = 0, fails = 0;
  bit done = 0;

  // bench model
  logic [AW-1:0] mReg [4];
  logic          mRec, mTr;

  xfr_recorder i_xfr_recorder (
    .clk(clk), .rstN(rstN), .evtValid(evtValid), .evtKind(evtKind),
    .evtFrom(evtFrom), .evtTo(evtTo), .cfgWe(cfgWe), .cfgWdata(cfgWdata),
    .cfgRdata(cfgRdata), .rdSel(rdSel), .rdData(rdData)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [CW-1:0] expCfg();
    logic [CW-1:0] v = '0;
    v[0] = mRec;
    v[6] = mTr;
    return v;
  endfunction

  task automatic check32(string tag, string what, logic [AW-1:0] act, logic [AW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic checkAll(string tag);
    for (int s = 0; s < 4; s++) begin
      rdSel = 2'(s);
      #1;
      check32(tag, $sformatf("reg%0d", s), rdData, mReg[s]);
    end
    check32(tag, "cfg", AW'(cfgRdata), AW'(expCfg()));
  endtask

  // one stimulus cycle: drive at negedge, model the edge, read back before next negedge
  task automatic step(string tag, bit v, logic [1:0] k, logic [AW-1:0] f, logic [AW-1:0] t,
                      bit we, logic [CW-1:0] wd);
    bit on;
    evtValid = v; evtKind = k; evtFrom = f; evtTo = t; cfgWe = we; cfgWdata = wd;
    @(posedge clk);
    on = mRec && !mTr;
    if (v && on && k != 2'd3) begin
      if (k != 2'd0) begin
        mReg[2] = mReg[0];
        mReg[3] = mReg[1];
      end
      mReg[0] = f;
      mReg[1] = t;
    end
    if (we) begin
      mRec = wd[0];
      mTr  = wd[6];
    end
    if (v && k == 2'd3) mRec = 1'b0;
    #0.5;
    evtValid = 0; cfgWe = 0;
    checkAll(tag);
    @(negedge clk);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finishRun();
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    rstN = 0; evtValid = 0; evtKind = 0; evtFrom = '0; evtTo = '0;
    cfgWe = 0; cfgWdata = '0; rdSel = 0;
    for (int i = 0; i < 4; i++) mReg[i] = '0;
    mRec = 0; mTr = 0;
    repeat (3) @(negedge clk);
    checkAll("R1");
    // R1: event with recording requested during reset still leaves zeros
    evtValid = 1; evtFrom = 32'hdead; cfgWe = 1; cfgWdata = 8'hff;
    @(negedge clk);
    checkAll("R1");
    rstN = 1;
    // R5: recording off, events ignored
    step("R5", 1, 2'd0, 32'h1111_0000, 32'h2222_0000, 0, 8'h00);
    step("R5", 1, 2'd2, 32'h1111_0001, 32'h2222_0001, 0, 8'h00);
    // R7: write all ones, only bits 0 and 6 survive; same-cycle event uses old flag (off)
    step("R7", 1, 2'd0, 32'haaaa_0000, 32'hbbbb_0000, 1, 8'hff);
    // R6: trace flag set, events ignored
    step("R6", 1, 2'd0, 32'haaaa_0001, 32'hbbbb_0001, 0, 8'h00);
    step("R6", 1, 2'd1, 32'haaaa_0002, 32'hbbbb_0002, 0, 8'h00);
    step("R7", 0, 2'd0, '0, '0, 1, 8'h01);
    // R2 / R3 / R9 back to back
    step("R2", 1, 2'd0, 32'h0000_1000, 32'h0000_2000, 0, 8'h00);
    step("R3", 1, 2'd1, 32'h0000_1004, 32'h0000_8000, 0, 8'h00);
    step("R9", 1, 2'd2, 32'h0000_8010, 32'h0000_9000, 0, 8'h00);
    step("R8", 1, 2'd0, 32'hffff_fffe, 32'h0000_0001, 0, 8'h00);
    // R4: debug exception with concurrent set-write: flag ends clear, regs frozen
    step("R4", 1, 2'd3, 32'h5555_5555, 32'h6666_6666, 1, 8'h01);
    step("R4", 1, 2'd1, 32'h7777_7777, 32'h8888_8888, 0, 8'h00);
    step("R7", 1, 2'd2, 32'h9999_0000, 32'h9999_1111, 1, 8'h01);
    step("R3", 1, 2'd2, 32'h9999_2222, 32'h9999_3333, 0, 8'h00);
    // random phase
    for (int n = 0; n < 400; n++) begin
      logic [1:0] k;
      bit we;
      logic [CW-1:0] wd;
      string tag;
      k  = 2'($urandom_range(0, 3));
      if ($urandom_range(0, 7) == 0) k = 2'd3; else if (k == 2'd3) k = 2'd0;
      we = ($urandom_range(0, 5) == 0);
      wd = CW'($urandom);
      if ($urandom_range(0, 1) == 1) wd[6] = 1'b0;
      if (we && $urandom_range(0, 1) == 1) wd[0] = 1'b1;
      tag = (k == 2'd0) ? "R2" : (k == 2'd3) ? "R4" : "R3";
      step(tag, $urandom_range(0, 4) != 0, k, $urandom, $urandom, we, wd);
    end
    finishRun();
  end
endmodule